// File: doc/BRIEF.md
# Inertial Sensor Register Bank with Coherent Byte Reads

This block is the byte-wide register file of a three-axis inertial sensor. It holds four 16-bit channels: X, Y and Z acceleration and temperature. Each channel can be read as a high byte and a low byte. Reading the high byte of a channel copies that channel's current low byte into a holding register. A later read of the low byte returns the held copy, so the two bytes always come from the same sample, even if a new sample arrives between the two reads.

The bank also holds the following:
- a read/write control byte;
- a status byte with a checksum-error bit and a frame-error bit;
- a sticky fault byte, cleared by reading it, with saturation, start-up self-test and continuous self-test bits;
- a constant identification byte;
- a reset register that raises a one-cycle component-reset pulse only after the ordered key 0Ch, 05h, 0Fh is written to it.

Summary flags for the serial frame are driven out continuously.

Samples enter on a valid/ready handshake. `smp_ready` rises one cycle after reset is released and stays high, so the bank never applies back-pressure. A sample is taken on any cycle where both `smp_valid` and `smp_ready` are high. The register bus uses plain strobes. `rd_data` is registered, updates one cycle after an `rd_en` cycle, and otherwise holds its value.

Top module: `sens_regbank`

## Requirements
- R1: Address 01h is a read/write control byte. Its value is driven on `ctrl_q` and reads back, and it is 00h after reset.
- R2: A read of a high-byte address (X 05h, Y 07h, Z 09h, temperature 13h) returns the live high byte. The same read copies the live low byte into that channel's holding register. A read of the low-byte address (04h, 06h, 08h, 12h) returns the holding register, which is 00h after reset. Read data appears on `rd_data` one cycle after the `rd_en` cycle.
- R3: Address 27h always reads 90h, and writes to it have no effect.
- R4: Address 02h reads {6'b0, checksum error, frame error}. The checksum bit is `csum_err` registered by one cycle.
- R5: The frame-error flag sets on `frame_bad` and clears on `frame_good`. When both arrive in the same cycle, set wins. The flag is driven on `flag_frame`.
- R6: Address 16h reads {1'b0, saturation, start-up self-test fail, continuous self-test fail, 4'b0}. Each bit is sticky: it sets on its event input and stays set after the event goes away.
- R7: A read of 16h clears all three sticky bits, and the read returns their value from before the clear. A bit whose event is high in the same cycle as the read stays set.
- R8: Writing 0Ch, 05h and 0Fh to 03h, in that order, raises `comp_reset` for exactly one cycle, in the cycle after the 0Fh write. Address 03h reads back the last byte written to it.
- R9: A wrong or out-of-order byte written to 03h abandons the sequence. If that byte is 0Ch, it counts as the first step of a new attempt.
- R10: Reads of unmapped addresses return 00h. Writes to read-only or unmapped addresses change no readable state.
- R11: `flag_selftest` is the OR of the checksum bit and the two sticky self-test bits. `flag_sat` is the sticky saturation bit.
- R12: `smp_ready` is low in reset and goes high one cycle after reset is released. Loaded sample values are visible to reads from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| smp_valid | input | 1 | New sample valid |
| smp_ready | output | 1 | Sample accepted (always high after reset) |
| x_smp | input | 16 | X-axis sample |
| y_smp | input | 16 | Y-axis sample |
| z_smp | input | 16 | Z-axis sample |
| t_smp | input | 16 | Temperature sample |
| csum_err | input | 1 | Checksum error level |
| frame_bad | input | 1 | Malformed frame seen |
| frame_good | input | 1 | Well-formed frame seen |
| sat_evt | input | 1 | Axis saturation event |
| sts_evt | input | 1 | Start-up self-test failure event |
| stc_evt | input | 1 | Continuous self-test failure event |
| ctrl_q | output | 8 | Control register value |
| comp_reset | output | 1 | One-cycle component reset pulse |
| flag_selftest | output | 1 | Summary self-test flag for the frame |
| flag_sat | output | 1 | Saturation flag for the frame |
| flag_frame | output | 1 | Frame-error flag for the frame |

## Verification
The assertions take the strobes and event inputs to be known values on every clock after reset. They allow `frame_bad` and `frame_good` to be high together, and they let events coincide with reads of 16h. They also allow reads and writes in the same cycle, but the stimulus never drives `rd_en` and `wr_en` together, so each bus cycle has one meaning. All inputs change on the falling clock edge and stay stable through the rising edge. The bench deliberately makes events coincide with acknowledging reads, makes a new sample arrive between a high-byte read and its low-byte read, and cuts off or restarts key sequences.

// File: rtl/sens_regbank_pkg.sv
package sens_regbank_pkg;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int N_CH   = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h01;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h02;
  localparam logic [ADDR_W-1:0] A_UNLOCK = 8'h03;
  localparam logic [ADDR_W-1:0] A_FAULT  = 8'h16;
  localparam logic [ADDR_W-1:0] A_IDENT  = 8'h27;

  // low-byte address of each channel; the high byte sits one above
  localparam logic [ADDR_W-1:0] CH_LO_ADDR [N_CH] = '{8'h04, 8'h06, 8'h08, 8'h12};

  localparam logic [BYTE_W-1:0] IDENT_VAL = 8'h90;
  localparam logic [BYTE_W-1:0] KEY_A = 8'h0C;
  localparam logic [BYTE_W-1:0] KEY_B = 8'h05;
  localparam logic [BYTE_W-1:0] KEY_C = 8'h0F;

  typedef enum logic [1:0] {UL_IDLE, UL_ONE, UL_TWO} unlock_st_t;
endpackage

// File: rtl/sens_lsb_hold.sv
module sens_lsb_hold #(
  parameter int SMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SMP_W-1:0]   smp_in,
  input  logic               hi_rd,
  output logic [SMP_W/2-1:0] live_hi,
  output logic [SMP_W/2-1:0] held_lo
);
  localparam int HW = SMP_W / 2;

  logic [SMP_W-1:0] live_q;
  logic [HW-1:0]    held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      held_q <= '0;
    end else begin
      if (load)  live_q <= smp_in;
      if (hi_rd) held_q <= live_q[HW-1:0];
    end
  end

  assign live_hi = live_q[SMP_W-1:HW];
  assign held_lo = held_q;
endmodule

// File: rtl/sens_fault_flags.sv
module sens_fault_flags #(
  parameter int N_STICKY = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csum_in,
  input  logic                frame_bad,
  input  logic                frame_good,
  input  logic [N_STICKY-1:0] evt,
  input  logic                ack,
  output logic                csum_q,
  output logic                frame_q,
  output logic [N_STICKY-1:0] sticky_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csum_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      csum_q <= csum_in;
      if (frame_bad)       frame_q <= 1'b1;
      else if (frame_good) frame_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rst_n) sticky_q[i] <= 1'b0;
      else        sticky_q[i] <= evt[i] | (sticky_q[i] & ~ack);
    end
  end
endmodule

// File: rtl/sens_unlock_seq.sv
module sens_unlock_seq
  import sens_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [BYTE_W-1:0] key,
  output logic              fire
);
  unlock_st_t st_q, st_d;
  logic       fire_d;

  always_comb begin
    st_d   = st_q;
    fire_d = 1'b0;
    if (key_wr) begin
      fire_d = (st_q == UL_TWO) && (key == KEY_C);
      if (key == KEY_A)                           st_d = UL_ONE;
      else if ((st_q == UL_ONE) && (key == KEY_B)) st_d = UL_TWO;
      else                                        st_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= UL_IDLE;
      fire <= 1'b0;
    end else begin
      st_q <= st_d;
      fire <= fire_d;
    end
  end
endmodule

// File: rtl/sens_regbank.sv
module sens_regbank
  import sens_regbank_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  x_smp,
  input  logic [SMP_W-1:0]  y_smp,
  input  logic [SMP_W-1:0]  z_smp,
  input  logic [SMP_W-1:0]  t_smp,
  input  logic              csum_err,
  input  logic              frame_bad,
  input  logic              frame_good,
  input  logic              sat_evt,
  input  logic              sts_evt,
  input  logic              stc_evt,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              comp_reset,
  output logic              flag_selftest,
  output logic              flag_sat,
  output logic              flag_frame
);
  localparam int HW = SMP_W / 2;

  logic [SMP_W-1:0] smp_arr [N_CH];
  logic [HW-1:0]    live_hi [N_CH];
  logic [HW-1:0]    held_lo [N_CH];
  logic [N_CH-1:0]  hi_rd;
  logic             load;
  logic [BYTE_W-1:0] unlock_q;
  logic             csum_q, frame_q;
  logic [2:0]       sticky_q;   // [2]=sat [1]=startup [0]=continuous
  logic             fault_ack;
  logic [BYTE_W-1:0] rd_next;

  assign smp_arr[0] = x_smp;
  assign smp_arr[1] = y_smp;
  assign smp_arr[2] = z_smp;
  assign smp_arr[3] = t_smp;
  assign load = smp_valid & smp_ready;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign hi_rd[c] = rd_en && (addr == CH_LO_ADDR[c] + 1'b1);
    sens_lsb_hold #(.SMP_W(SMP_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .smp_in  (smp_arr[c]),
      .hi_rd   (hi_rd[c]),
      .live_hi (live_hi[c]),
      .held_lo (held_lo[c])
    );
  end

  assign fault_ack = rd_en && (addr == A_FAULT);

  sens_fault_flags #(.N_STICKY(3)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .csum_in    (csum_err),
    .frame_bad  (frame_bad),
    .frame_good (frame_good),
    .evt        ({sat_evt, sts_evt, stc_evt}),
    .ack        (fault_ack),
    .csum_q     (csum_q),
    .frame_q    (frame_q),
    .sticky_q   (sticky_q)
  );

  sens_unlock_seq u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_wr (wr_en && (addr == A_UNLOCK)),
    .key    (wr_data),
    .fire   (comp_reset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      unlock_q  <= '0;
      smp_ready <= 1'b0;
      rd_data   <= '0;
    end else begin
      smp_ready <= 1'b1;
      if (wr_en && addr == A_CTRL)   ctrl_q   <= wr_data;
      if (wr_en && addr == A_UNLOCK) unlock_q <= wr_data;
      if (rd_en) rd_data <= rd_next;
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      A_CTRL:   rd_next = ctrl_q;
      A_STATUS: rd_next = {6'b0, csum_q, frame_q};
      A_UNLOCK: rd_next = unlock_q;
      A_FAULT:  rd_next = {1'b0, sticky_q, 4'b0};
      A_IDENT:  rd_next = IDENT_VAL;
      default:  rd_next = '0;
    endcase
    for (int c = 0; c < N_CH; c++) begin
      if (addr == CH_LO_ADDR[c])        rd_next = held_lo[c];
      if (addr == CH_LO_ADDR[c] + 1'b1) rd_next = live_hi[c];
    end
  end

  assign flag_selftest = csum_q | sticky_q[1] | sticky_q[0];
  assign flag_sat      = sticky_q[2];
  assign flag_frame    = frame_q;
endmodule

// File: rtl/sens_regbank_chk.sv
module sens_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       frame_bad,
  input logic       frame_good,
  input logic       flag_frame,
  input logic       sat_evt,
  input logic       flag_sat,
  input logic       comp_reset
);
  AST_IDENT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'h27 |=> rd_data == 8'h90); // R3
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'h02 |=> rd_data[7:2] == 6'b0); // R4
  AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> flag_frame); // R5
  AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good && !frame_bad |=> !flag_frame); // R5
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sat && !(rd_en && addr == 8'h16) |=> flag_sat); // R6
  AST_SAT_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> flag_sat); // R7
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    comp_reset |=> !comp_reset); // R8
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    comp_reset |-> $past(wr_en && addr == 8'h03 && wr_data == 8'h0F)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 8'h30 |=> rd_data == 8'h00); // R10
endmodule

bind sens_regbank sens_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .frame_bad  (frame_bad),
  .frame_good (frame_good),
  .flag_frame (flag_frame),
  .sat_evt    (sat_evt),
  .flag_sat   (flag_sat),
  .comp_reset (comp_reset)
);

// File: tb/tb_sens_regbank.sv
module tb_sens_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, smp_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [15:0] x_smp = '0, y_smp = '0, z_smp = '0, t_smp = '0;
  logic csum_err = 1'b0, frame_bad = 1'b0, frame_good = 1'b0;
  logic sat_evt = 1'b0, sts_evt = 1'b0, stc_evt = 1'b0;
  logic [7:0] rd_data, ctrl_q;
  logic smp_ready, comp_reset, flag_selftest, flag_sat, flag_frame;

  int checks = 0, errors = 0, cycles = 0, pulses = 0;

  always #5 clk = ~clk;

  sens_regbank dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .x_smp(x_smp), .y_smp(y_smp), .z_smp(z_smp), .t_smp(t_smp),
    .csum_err(csum_err), .frame_bad(frame_bad), .frame_good(frame_good),
    .sat_evt(sat_evt), .sts_evt(sts_evt), .stc_evt(stc_evt),
    .ctrl_q(ctrl_q), .comp_reset(comp_reset), .flag_selftest(flag_selftest),
    .flag_sat(flag_sat), .flag_frame(flag_frame)
  );

  // behavioural reference model
  int   lo_addr [4] = '{'h04, 'h06, 'h08, 'h12};
  int   m_live [4];
  int   m_hold [4];
  int   m_ctrl, m_unl, m_step, m_rd, m_csum, m_frame, m_sat, m_sts, m_stc;
  bit   m_ready, m_pulse;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_live[i]) begin m_live[i] = 0; m_hold[i] = 0; end
      m_ctrl = 0; m_unl = 0; m_step = 0; m_rd = 0; m_csum = 0; m_frame = 0;
      m_sat = 0; m_sts = 0; m_stc = 0; m_ready = 0; m_pulse = 0;
    end else begin
      bit ack;
      int a;
      a = addr;
      ack = rd_en && a == 'h16;
      if (rd_en) begin
        m_rd = 0; m_tag = "R10";
        case (a)
          'h01: begin m_rd = m_ctrl; m_tag = "R1"; end
          'h02: begin m_rd = m_csum * 2 + m_frame; m_tag = "R4"; end
          'h03: begin m_rd = m_unl; m_tag = "R8"; end
          'h16: begin m_rd = m_sat * 64 + m_sts * 32 + m_stc * 16; m_tag = "R7"; end
          'h27: begin m_rd = 'h90; m_tag = "R3"; end
          default: ;
        endcase
        for (int c = 0; c < 4; c++) begin
          if (a == lo_addr[c]) begin m_rd = m_hold[c]; m_tag = "R2"; end
          if (a == lo_addr[c] + 1) begin
            m_rd = m_live[c] / 256; m_tag = "R2";
            m_hold[c] = m_live[c] % 256;
          end
        end
      end
      m_pulse = 0;
      if (wr_en && a == 'h01) m_ctrl = wr_data;
      if (wr_en && a == 'h03) begin
        m_unl = wr_data;
        m_pulse = (m_step == 2 && wr_data == 8'h0F);
        if (wr_data == 8'h0C) m_step = 1;
        else if (m_step == 1 && wr_data == 8'h05) m_step = 2;
        else m_step = 0;
      end
      if (smp_valid && m_ready) begin
        m_live[0] = x_smp; m_live[1] = y_smp; m_live[2] = z_smp; m_live[3] = t_smp;
      end
      m_ready = 1;
      m_csum = csum_err;
      if (frame_bad) m_frame = 1; else if (frame_good) m_frame = 0;
      m_sat = (sat_evt || (m_sat && !ack)) ? 1 : 0;
      m_sts = (sts_evt || (m_sts && !ack)) ? 1 : 0;
      m_stc = (stc_evt || (m_stc && !ack)) ? 1 : 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare on every falling edge once out of reset
  always @(negedge clk) begin
    cycles++;
    if (rst_n && cycles > 2) begin
      chk(m_tag, rd_data, m_rd);
      chk("R1", ctrl_q, m_ctrl);
      chk("R8 R9", comp_reset, m_pulse);
      chk("R5", flag_frame, m_frame);
      chk("R11", flag_selftest, (m_csum | m_sts | m_stc));
      chk("R11 R6", flag_sat, m_sat);
      chk("R12", smp_ready, m_ready);
      if (comp_reset) pulses++;
    end
  end

  always @(negedge clk) if (cycles > 100000) begin
    errors++;
    $display("FAIL watchdog: actual %0d expected below 100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0; smp_valid = 0; frame_bad = 0; frame_good = 0;
    sat_evt = 0; sts_evt = 0; stc_evt = 0;
  endtask
  task automatic wr(int a, int d);
    @(negedge clk); addr = a[7:0]; wr_data = d[7:0]; wr_en = 1; rd_en = 0;
    idle();
  endtask
  task automatic rd(int a);
    @(negedge clk); addr = a[7:0]; rd_en = 1; wr_en = 0;
    idle();
  endtask
  task automatic load(int x, int y, int z, int t);
    @(negedge clk); x_smp = x[15:0]; y_smp = y[15:0]; z_smp = z[15:0]; t_smp = t[15:0];
    smp_valid = 1;
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R12: ready low in reset)
    chk("R12", smp_ready, 0);
    chk("R1", ctrl_q, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12", smp_ready, 1);
    // R2: coherent pairs
    rd('h04);
    load('h1234, 'hABCD, 'h0F0F, 'h8001);
    rd('h05);
    load('h5678, 'h1111, 'h2222, 'h3333);
    rd('h04);
    chk("R2", rd_data, 'h34);
    rd('h07); rd('h06); rd('h13); rd('h12); rd('h09); rd('h08);
    // R1 / R3 / R10
    wr('h01, 'h5A); rd('h01);
    chk("R1", rd_data, 'h5A);
    wr('h27, 'h11); rd('h27);
    chk("R3", rd_data, 'h90);
    wr('h16, 'hFF); wr('h02, 'hFF); wr('h30, 'h77); rd('h30);
    chk("R10", rd_data, 0);
    rd('h16);
    chk("R10", rd_data, 0);
    // R4 / R5
    csum_err = 1; rd('h02); rd('h02);
    @(negedge clk); frame_bad = 1; idle(); rd('h02);
    @(negedge clk); frame_good = 1; idle(); rd('h02);
    @(negedge clk); frame_bad = 1; frame_good = 1; idle(); rd('h02);
    chk("R5", rd_data, 3);
    csum_err = 0;
    @(negedge clk); frame_good = 1; idle();
    // R6 / R7 sticky and acknowledge
    @(negedge clk); sat_evt = 1; idle();
    idle(); rd('h16);
    chk("R6", rd_data, 'h40);
    rd('h16);
    chk("R7", rd_data, 0);
    @(negedge clk); sts_evt = 1; stc_evt = 1; idle();
    @(negedge clk); addr = 'h16; rd_en = 1; sts_evt = 1; idle();
    chk("R7", rd_data, 'h30);
    rd('h16);
    chk("R7", rd_data, 'h20);
    rd('h16);
    // R8 / R9 unlock sequences
    wr('h03, 'h0C); wr('h03, 'h05); wr('h03, 'h0F);
    wr('h03, 'h0C); wr('h03, 'h05); wr('h03, 'h0C); wr('h03, 'h05); wr('h03, 'h0F);
    wr('h03, 'h0C); wr('h03, 'h0F);
    wr('h03, 'h05); wr('h03, 'h0F);
    wr('h03, 'h0C); wr('h03, 'h0C); wr('h03, 'h05); wr('h03, 'h0F);
    wr('h03, 'h0C); wr('h01, 'h00); wr('h03, 'h05); wr('h03, 'h0F);
    rd('h03);
    chk("R8", rd_data, 'h0F);
    chk("R9", pulses, 4);
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int sel;
      int ad [16] = '{'h01,'h02,'h03,'h04,'h05,'h06,'h07,'h08,
                     'h09,'h12,'h13,'h16,'h27,'h00,'h0A,'h03};
      sel = $urandom_range(0, 15);
      @(negedge clk);
      addr = ad[sel][7:0];
      wr_data = (sel == 15) ? 8'h0C : 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) rd_en = 1; else wr_en = 1;
      smp_valid = ($urandom_range(0, 3) == 0);
      x_smp = 16'($urandom); y_smp = 16'($urandom); z_smp = 16'($urandom); t_smp = 16'($urandom);
      csum_err = ($urandom_range(0, 7) == 0);
      frame_bad = ($urandom_range(0, 7) == 0);
      frame_good = ($urandom_range(0, 3) == 0);
      sat_evt = ($urandom_range(0, 9) == 0);
      sts_evt = ($urandom_range(0, 9) == 0);
      stc_evt = ($urandom_range(0, 9) == 0);
      idle();
    end
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule